// File: doc/BRIEF.md
# Interleaved Memory Port-to-System Address Translator

This block turns a right-justified memory-port address, as seen by one channel of a memory controller, into the full system real address. The channel sits inside an interleave group that spans 1, 2, 3, 4, 6 or 8 channels. For power-of-two groups, plain group-select bits are spliced into the address. For three- and six-channel groups, the address is spread across channels by a modulo-3 hash. A companion solver supplies the two high-order bits that the hash needs, and this block places them at a position set by the group size.

A range mode serves callers that translate the start and end of a region. In a hashed group they cannot rely on the real high bits, because a start address may hash above its end address. In range mode the block substitutes fixed high bits so that the start always lies at or below the end. The result is registered. It appears one cycle after the input strobe, together with an error flag for configuration codes the block does not recognise.

Top module: `mem_port_xlat`

## Requirements
- R1: The 4-bit configuration code maps to channels per group as follows: 0→1, 3→3, 4→2, 5→2, 6→4, 7→6 and 8→8. Code 1 gives 1 channel at position 0 and 3 channels at position 1. Code 2 gives 3 channels at position 0 and 1 channel at position 1.
- R2: Port address bits 39:7 are shifted left by k, and group-ID bits k-1:0 are placed starting at bit 7. k is 0 for 1 or 3 channels, 1 for 2 or 6 channels, 2 for 4 channels and 3 for 8 channels.
- R3: Port address bits 6:0 appear unchanged in output bits 6:0 for every valid configuration.
- R4: For 3- or 6-channel groups, the 2-bit hash value is ORed into the address with its low bit at position 30 plus the number of ones in the 11-bit group-size mask.
- R5: For groups of 1, 2, 4 or 8 channels, the hash value input has no effect on the output.
- R6: In range mode with a 3- or 6-channel group, the hash value is replaced by 00 when the end select is low (start address) and by 10 when it is high (end address). Range mode has no effect on other group sizes.
- R7: Channel position 0 always uses the primary base. Position 1 uses the secondary base for codes 0 to 4 and the primary base for codes 5 to 8.
- R8: The selected 24-bit base is ORed into output bits 55:32.
- R9: A configuration code above 8 sets the error flag and drives the output address to zero.
- R10: The output valid equals the input strobe delayed by one clock. Address and error are loaded only on strobed cycles and hold otherwise.
- R11: After reset, the output valid, the output address and the error flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe; inputs are taken when high |
| port_addr | input | 40 | Right-justified memory-port address |
| cfg_code | input | 4 | Group configuration code |
| chan_pos | input | 1 | Channel position within the controller pair |
| grp_id | input | 3 | Group identifier |
| grp_size | input | 11 | Group-size mask |
| bar_pri | input | 24 | Primary base address |
| bar_sec | input | 24 | Secondary base address |
| hash_msb | input | 2 | High-order bits from the hash solver |
| range_mode | input | 1 | Force fixed high bits for region bounds |
| range_end | input | 1 | In range mode: 0 = start bound, 1 = end bound |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| sys_addr | output | 64 | System real address |
| cfg_err | output | 1 | Unsupported configuration code |

## Verification
Every result (address, error flag and valid) is due exactly one clock edge after the strobed cycle, because the only register on the path is the output stage. The bench drives inputs at the falling edge, so one rising edge loads the result, and it samples at the next falling edge. Hold behaviour is checked one further cycle later, with the strobe low and the inputs changed. Reset values are sampled at a falling edge while reset is still asserted.

// File: rtl/mem_port_xlat_pkg.sv
package mem_port_xlat_pkg;

   // Decoded view of one configuration code at one channel position.
   typedef struct packed {
      logic [3:0] chans;    // channels per group
      logic [1:0] ins_k;    // group-ID bits spliced in
      logic       hashed;   // modulo-3 interleave (3 or 6 channels)
      logic       use_sec;  // take the secondary base
      logic       bad;      // unsupported code or channel count
   } grp_dec_t;

   localparam logic [3:0] LAST_CODE = 4'd8;

   // Highest code whose position-1 channel sits in its own group.
   localparam logic [3:0] LAST_SPLIT_CODE = 4'd4;

endpackage

// File: rtl/mem_port_xlat_decode.sv
module mem_port_xlat_decode
   import mem_port_xlat_pkg::*;
(
   input  logic [3:0] cfg_code,
   input  logic       chan_pos,
   output grp_dec_t   dec
);

   logic [3:0] chans;

   always_comb begin
      chans = 4'd0;
      unique case (cfg_code)
         4'd0:    chans = 4'd1;
         4'd1:    chans = chan_pos ? 4'd3 : 4'd1;
         4'd2:    chans = chan_pos ? 4'd1 : 4'd3;
         4'd3:    chans = 4'd3;
         4'd4:    chans = 4'd2;
         4'd5:    chans = 4'd2;
         4'd6:    chans = 4'd4;
         4'd7:    chans = 4'd6;
         4'd8:    chans = 4'd8;
         default: chans = 4'd0;
      endcase
   end

   always_comb begin
      dec         = '0;
      dec.chans   = chans;
      dec.use_sec = chan_pos && (cfg_code <= LAST_SPLIT_CODE);
      dec.bad     = (cfg_code > LAST_CODE);
      unique case (chans)
         4'd1:    dec.ins_k = 2'd0;
         4'd3: begin
            dec.ins_k  = 2'd0;
            dec.hashed = 1'b1;
         end
         4'd2:    dec.ins_k = 2'd1;
         4'd6: begin
            dec.ins_k  = 2'd1;
            dec.hashed = 1'b1;
         end
         4'd4:    dec.ins_k = 2'd2;
         4'd8:    dec.ins_k = 2'd3;
         default: dec.bad   = 1'b1;
      endcase
   end

endmodule

// File: rtl/mem_port_xlat_gid.sv
module mem_port_xlat_gid #(
   parameter int PORT_AW = 40,
   parameter int GID_W   = 3,
   parameter int KEEP_LO = 7,
   parameter int SYS_AW  = 64,
   localparam int KW     = $clog2(GID_W + 1)
) (
   input  logic [PORT_AW-1:0] port_addr,
   input  logic [GID_W-1:0]   grp_id,
   input  logic [KW-1:0]      ins_k,
   output logic [SYS_AW-1:0]  spliced
);

   localparam int HI_W = PORT_AW - KEEP_LO;

   logic [SYS_AW-1:0] hi_part;
   logic [SYS_AW-1:0] lo_part;
   logic [SYS_AW-1:0] cand [GID_W+1];

   assign hi_part = SYS_AW'(port_addr[PORT_AW-1:KEEP_LO]);
   assign lo_part = SYS_AW'(port_addr[KEEP_LO-1:0]);

   for (genvar kk = 0; kk <= GID_W; kk++) begin : g_k
      if (kk == 0) begin : g_none
         assign cand[kk] = (hi_part << KEEP_LO) | lo_part;
      end else begin : g_ins
         assign cand[kk] = (hi_part << (KEEP_LO + kk))
                         | (SYS_AW'(grp_id[kk-1:0]) << KEEP_LO)
                         | lo_part;
      end
   end

   always_comb begin
      spliced = cand[0];
      for (int i = 0; i <= GID_W; i++) begin
         if (KW'(i) == ins_k) spliced = cand[i];
      end
   end

   if (HI_W < 1) begin : g_bad_keep
      $error("KEEP_LO must leave port bits above it");
   end

endmodule

// File: rtl/mem_port_xlat_msb.sv
module mem_port_xlat_msb #(
   parameter int GSIZE_W  = 11,
   parameter int MSB_BASE = 30,
   parameter int SYS_AW   = 64,
   localparam int CNT_W   = $clog2(GSIZE_W + 1)
) (
   input  logic [GSIZE_W-1:0] grp_size,
   input  logic               hashed,
   input  logic [1:0]         hash_msb,
   input  logic               range_mode,
   input  logic               range_end,
   output logic [SYS_AW-1:0]  msb_bits
);

   localparam logic [1:0] START_MSB = 2'b00;
   localparam logic [1:0] END_MSB   = 2'b10;

   logic [CNT_W-1:0] ones;
   logic [1:0]       msb_eff;

   always_comb begin
      ones = '0;
      for (int i = 0; i < GSIZE_W; i++) begin
         ones = ones + CNT_W'(grp_size[i]);
      end
   end

   assign msb_eff  = range_mode ? (range_end ? END_MSB : START_MSB) : hash_msb;
   assign msb_bits = hashed ? (SYS_AW'(msb_eff) << (MSB_BASE + int'(ones)))
                            : '0;

   if (MSB_BASE + GSIZE_W + 2 > SYS_AW) begin : g_bad_msb
      $error("hash bits can land outside the system address");
   end

endmodule

// File: rtl/mem_port_xlat.sv
module mem_port_xlat
   import mem_port_xlat_pkg::*;
#(
   parameter int PORT_AW   = 40,
   parameter int GID_W     = 3,
   parameter int GSIZE_W   = 11,
   parameter int BAR_W     = 24,
   parameter int SYS_AW    = 64,
   parameter int KEEP_LO   = 7,
   parameter int MSB_BASE  = 30,
   parameter int BAR_SHIFT = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [PORT_AW-1:0] port_addr,
   input  logic [3:0]         cfg_code,
   input  logic               chan_pos,
   input  logic [GID_W-1:0]   grp_id,
   input  logic [GSIZE_W-1:0] grp_size,
   input  logic [BAR_W-1:0]   bar_pri,
   input  logic [BAR_W-1:0]   bar_sec,
   input  logic [1:0]         hash_msb,
   input  logic               range_mode,
   input  logic               range_end,
   output logic               out_valid,
   output logic [SYS_AW-1:0]  sys_addr,
   output logic               cfg_err
);

   localparam int KW = $clog2(GID_W + 1);

   grp_dec_t          dec;
   logic [SYS_AW-1:0] spliced;
   logic [SYS_AW-1:0] msb_bits;
   logic [SYS_AW-1:0] bar_bits;
   logic [SYS_AW-1:0] addr_nxt;

   mem_port_xlat_decode u_decode (
      .cfg_code (cfg_code),
      .chan_pos (chan_pos),
      .dec      (dec)
   );

   mem_port_xlat_gid #(
      .PORT_AW (PORT_AW),
      .GID_W   (GID_W),
      .KEEP_LO (KEEP_LO),
      .SYS_AW  (SYS_AW)
   ) u_gid (
      .port_addr (port_addr),
      .grp_id    (grp_id),
      .ins_k     (KW'(dec.ins_k)),
      .spliced   (spliced)
   );

   mem_port_xlat_msb #(
      .GSIZE_W  (GSIZE_W),
      .MSB_BASE (MSB_BASE),
      .SYS_AW   (SYS_AW)
   ) u_msb (
      .grp_size   (grp_size),
      .hashed     (dec.hashed),
      .hash_msb   (hash_msb),
      .range_mode (range_mode),
      .range_end  (range_end),
      .msb_bits   (msb_bits)
   );

   assign bar_bits = SYS_AW'(dec.use_sec ? bar_sec : bar_pri) << BAR_SHIFT;
   assign addr_nxt = dec.bad ? '0 : (spliced | msb_bits | bar_bits);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         sys_addr  <= '0;
         cfg_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            sys_addr <= addr_nxt;
            cfg_err  <= dec.bad;
         end
      end
   end

   if (BAR_SHIFT + BAR_W > SYS_AW) begin : g_bad_bar
      $error("base field exceeds the system address width");
   end
   if (PORT_AW + GID_W > SYS_AW) begin : g_bad_port
      $error("spliced port address exceeds the system address width");
   end
   if (GID_W < 3) begin : g_bad_gid
      $error("eight-channel groups need three group-ID bits");
   end

endmodule

// File: rtl/mem_port_xlat_chk.sv
module mem_port_xlat_chk #(
   parameter int PORT_AW = 40,
   parameter int BAR_W   = 24,
   parameter int SYS_AW  = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [PORT_AW-1:0] port_addr,
   input logic [3:0]         cfg_code,
   input logic               chan_pos,
   input logic [10:0]        grp_size,
   input logic [BAR_W-1:0]   bar_pri,
   input logic               range_mode,
   input logic               range_end,
   input logic               out_valid,
   input logic [SYS_AW-1:0]  sys_addr,
   input logic               cfg_err
);

   p_valid_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(sys_addr) && $stable(cfg_err));

   p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cfg_code > 4'd8 |=> cfg_err && sys_addr == '0);

   p_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cfg_code <= 4'd8 |=> sys_addr[6:0] == $past(port_addr[6:0]));

   p_pri_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !chan_pos && cfg_code <= 4'd8
      |=> (sys_addr[55:32] & $past(bar_pri)) == $past(bar_pri));

   p_range_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && range_mode && range_end && cfg_code == 4'd3 && grp_size == '0
      |=> sys_addr[31]);

endmodule

bind mem_port_xlat mem_port_xlat_chk #(
   .PORT_AW (PORT_AW),
   .BAR_W   (BAR_W),
   .SYS_AW  (SYS_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .port_addr  (port_addr),
   .cfg_code   (cfg_code),
   .chan_pos   (chan_pos),
   .grp_size   (grp_size),
   .bar_pri    (bar_pri),
   .range_mode (range_mode),
   .range_end  (range_end),
   .out_valid  (out_valid),
   .sys_addr   (sys_addr),
   .cfg_err    (cfg_err)
);

// File: tb/mem_port_xlat_bench.sv
`timescale 1ns/1ps
module mem_port_xlat_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [39:0] port_addr = '0;
   logic [3:0]  cfg_code = '0;
   logic        chan_pos = 1'b0;
   logic [2:0]  grp_id = '0;
   logic [10:0] grp_size = '0;
   logic [23:0] bar_pri = '0;
   logic [23:0] bar_sec = '0;
   logic [1:0]  hash_msb = '0;
   logic        range_mode = 1'b0;
   logic        range_end = 1'b0;
   logic        out_valid;
   logic [63:0] sys_addr;
   logic        cfg_err;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   mem_port_xlat u_mem_port_xlat (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .port_addr (port_addr), .cfg_code (cfg_code), .chan_pos (chan_pos),
      .grp_id (grp_id), .grp_size (grp_size), .bar_pri (bar_pri),
      .bar_sec (bar_sec), .hash_msb (hash_msb), .range_mode (range_mode),
      .range_end (range_end), .out_valid (out_valid), .sys_addr (sys_addr),
      .cfg_err (cfg_err)
   );

   typedef struct packed {
      logic [3:0]  code;
      logic        pos;
      logic [2:0]  gid;
      logic [10:0] gsize;
      logic [1:0]  msb;
      logic        rmode;
      logic        rend;
      logic [39:0] port;
      logic [23:0] barp;
      logic [23:0] bars;
      logic [63:0] exp_addr;
      logic        exp_err;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VEC [NV] = '{
      '{4'd0, 1'b0, 3'd5, 11'h000, 2'd0, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_0000_0185, 1'b0, 4'd8},
      '{4'd0, 1'b1, 3'd5, 11'h000, 2'd0, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0002_0000_0185, 1'b0, 4'd7},
      '{4'd4, 1'b1, 3'd5, 11'h000, 2'd0, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0002_0000_0385, 1'b0, 4'd2},
      '{4'd5, 1'b1, 3'd5, 11'h000, 2'd0, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_0000_0385, 1'b0, 4'd7},
      '{4'd6, 1'b0, 3'd6, 11'h000, 2'd0, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_0000_0705, 1'b0, 4'd2},
      '{4'd8, 1'b0, 3'd5, 11'h000, 2'd0, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_0000_0E85, 1'b0, 4'd2},
      '{4'd3, 1'b0, 3'd3, 11'h000, 2'd3, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_C000_0185, 1'b0, 4'd4},
      '{4'd3, 1'b0, 3'd3, 11'h007, 2'd1, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0003_0000_0185, 1'b0, 4'd4},
      '{4'd7, 1'b1, 3'd3, 11'h000, 2'd2, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_8000_0385, 1'b0, 4'd4},
      '{4'd1, 1'b0, 3'd5, 11'h000, 2'd3, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_0000_0185, 1'b0, 4'd5},
      '{4'd1, 1'b1, 3'd5, 11'h000, 2'd3, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0002_C000_0185, 1'b0, 4'd1},
      '{4'd2, 1'b0, 3'd5, 11'h000, 2'd1, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_4000_0185, 1'b0, 4'd1},
      '{4'd2, 1'b1, 3'd5, 11'h000, 2'd3, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0002_0000_0185, 1'b0, 4'd5},
      '{4'd3, 1'b0, 3'd5, 11'h000, 2'd3, 1'b1, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0001_0000_0185, 1'b0, 4'd6},
      '{4'd3, 1'b0, 3'd5, 11'h000, 2'd1, 1'b1, 1'b1, 40'h185, 24'h1, 24'h2, 64'h0000_0001_8000_0185, 1'b0, 4'd6},
      '{4'd6, 1'b0, 3'd6, 11'h000, 2'd3, 1'b1, 1'b1, 40'h185, 24'h1, 24'h2, 64'h0000_0001_0000_0705, 1'b0, 4'd6},
      '{4'd9, 1'b0, 3'd5, 11'h000, 2'd3, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0,                   1'b1, 4'd9},
      '{4'd15,1'b1, 3'd5, 11'h000, 2'd3, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0,                   1'b1, 4'd9},
      '{4'd3, 1'b0, 3'd5, 11'h7FF, 2'd3, 1'b0, 1'b0, 40'h185, 24'h1, 24'h2, 64'h0000_0601_0000_0185, 1'b0, 4'd4},
      '{4'd8, 1'b0, 3'd0, 11'h000, 2'd0, 1'b0, 1'b0, 40'h80_0000_0000, 24'h1, 24'h2, 64'h0000_0401_0000_0000, 1'b0, 4'd2},
      '{4'd0, 1'b0, 3'd0, 11'h000, 2'd0, 1'b0, 1'b0, 40'h0, 24'hFFFFFF, 24'h2, 64'h00FF_FFFF_0000_0000, 1'b0, 4'd8}
   };

   function automatic string req_name(input logic [3:0] r);
      case (r)
         4'd1:    return "R1";
         4'd2:    return "R2";
         4'd4:    return "R4";
         4'd5:    return "R5";
         4'd6:    return "R6";
         4'd7:    return "R7";
         4'd8:    return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      cfg_code   = v.code;
      chan_pos   = v.pos;
      grp_id     = v.gid;
      grp_size   = v.gsize;
      hash_msb   = v.msb;
      range_mode = v.rmode;
      range_end  = v.rend;
      port_addr  = v.port;
      bar_pri    = v.barp;
      bar_sec    = v.bars;
   endtask

   initial begin : watchdog
      #500000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      in_valid = 1'b1;
      repeat (2) @(negedge clk);
      // R11: reset state with the strobe held high
      check("R11", 64'(out_valid), 64'd0);
      check("R11", sys_addr, 64'd0);
      check("R11", 64'(cfg_err), 64'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", 64'(out_valid), 64'd0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         in_valid = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check("R10", 64'(out_valid), 64'd1);
         check(req_name(VEC[i].req), sys_addr, VEC[i].exp_addr);
         check(req_name(VEC[i].req), 64'(cfg_err), 64'(VEC[i].exp_err));
      end

      // R3: low seven bits pass untouched through an eight-channel splice
      apply(VEC[5]);
      port_addr = 40'hAB_CDEF_127F;
      in_valid  = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R3", 64'(sys_addr[6:0]), 64'h7F);

      // R10: with the strobe low, new inputs leave the result alone
      begin
         logic [63:0] held;
         held = sys_addr;
         apply(VEC[16]);
         @(negedge clk);
         check("R10", 64'(out_valid), 64'd0);
         check("R10", sys_addr, held);
         check("R10", 64'(cfg_err), 64'd0);
      end

      // R9 then recovery: error clears on the next valid code
      in_valid = 1'b1;
      @(negedge clk);
      apply(VEC[0]);
      check("R9", 64'(cfg_err), 64'd1);
      @(negedge clk);
      in_valid = 1'b0;
      check("R9", 64'(cfg_err), 64'd0);
      check("R8", sys_addr, VEC[0].exp_addr);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule